// File: doc/BRIEF.md
# Grouped-Switch TDM Schedule Checker

This block watches a time-division schedule for a switch fabric whose linecards are split into equal groups. Each valid slot carries two things for every transmitting linecard: the linecard it sends to, and the index of the inter-group connection it uses. For each slot the block checks that no receiver is used twice. It also checks that no connection between a given sending group and a given receiving group carries more than one packet. Over a whole frame it keeps a transmitter-by-receiver coverage map, flags any pair that is scheduled twice, and confirms at the end of the frame that every pair was served.

A frame is NUM_LC valid slots long and begins with a start pulse, which may arrive on the first slot of the frame or on its own cycle. After each slot the block gives an error flag with a cause code. On the cycle that follows the last slot it gives a frame-done pulse, together with a frame-pass pulse when the frame was clean. A schedule generator or a test harness uses these results to accept or reject a schedule before it is loaded into the fabric.

Top module: `tdm_sched_check`

## Requirements
- R1: Transmitter i places its destination in `slotDest[i*DEST_W +: DEST_W]` and its connection index in `slotConn[i*CONN_W +: CONN_W]`. All results are registered and appear on the cycle after the slot's clock edge. A cycle without `slotValid` produces no error, no cause and no frame pulse.
- R2: If two transmitters in one slot name the same destination, the slot reports cause 1.
- R3: Linecard k belongs to group k/GRP_SIZE. If two transmitters in the same source group send to the same destination group over the same connection index, the slot reports cause 2. Equal indices used by different group pairs are legal.
- R4: If a slot schedules a transmitter-receiver pair that an earlier slot of the same frame already used, the slot reports cause 3.
- R5: When a slot has several causes, the lowest code is reported.
- R6: The NUM_LC-th valid slot after a frame start ends the frame. One cycle later `frameDone` pulses for one cycle, and the next valid slot begins a fresh frame with an empty coverage map.
- R7: `frameOk` pulses together with `frameDone` only when no slot of the frame reported an error and every one of the NUM_LC×NUM_LC pairs was covered.
- R8: If the last slot has no cause of its own but coverage is incomplete, that slot reports cause 4.
- R9: A `frameStart` pulse clears the coverage map, the slot count and the frame error history. When it coincides with `slotValid`, that slot is counted as slot 0 of the new frame.
- R10: `slotErr` is high exactly when `errCause` is nonzero. All outputs are low after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| slotValid | input | 1 | A slot is presented this cycle |
| frameStart | input | 1 | Begin a new frame (clears history) |
| slotDest | input | NUM_LC*DEST_W | Destination linecard of each transmitter |
| slotConn | input | NUM_LC*CONN_W | Connection index of each transmitter |
| slotErr | output | 1 | The previous slot broke a rule |
| errCause | output | 3 | Cause code for the previous slot (0 none) |
| frameDone | output | 1 | The previous slot closed a frame |
| frameOk | output | 1 | The frame just closed passed all checks |

## Verification
Every result comes from a single register stage, so the slot error, the cause, the frame-done pulse and the frame-pass pulse are all due on the first clock edge after the slot is applied. The bench drives each slot on a falling edge and reads all four outputs on the next falling edge. It then drops `slotValid` and reads again during the idle cycle to confirm that nothing is reported. The expected cause and frame outcome are computed beforehand from the bench's own coverage model.

// File: rtl/tdm_sched_pkg.sv
package tdm_sched_pkg;

  typedef enum logic [2:0] {
    CAUSE_NONE        = 3'd0,
    CAUSE_DUP_DEST    = 3'd1,
    CAUSE_CONN_OVER   = 3'd2,
    CAUSE_PAIR_REPEAT = 3'd3,
    CAUSE_PAIR_MISS   = 3'd4
  } cause_e;

  // strobes from control to datapath
  typedef struct packed {
    logic commit;      // a slot is accepted this cycle
    logic freshFrame;  // ignore stored coverage (frame start)
    logic wrapFrame;   // frame ends this cycle: empty the map
  } map_ctl_t;

endpackage

// File: rtl/tdm_sched_dp.sv
module tdm_sched_dp
  import tdm_sched_pkg::*;
#(
  parameter int NUM_LC   = 8,
  parameter int GRP_SIZE = 4,
  parameter int NUM_CONN = 5,
  parameter int DEST_W   = 3,
  parameter int CONN_W   = 3
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  map_ctl_t                 mapCtl,
  input  logic [NUM_LC*DEST_W-1:0] slotDest,
  input  logic [NUM_LC*CONN_W-1:0] slotConn,
  output logic                     dupDest,
  output logic                     connOver,
  output logic                     pairRepeat,
  output logic                     coverFull
);

  localparam int MAP_BITS = NUM_LC * NUM_LC;

  logic [NUM_LC-1:0][NUM_LC-1:0] dupHit;
  logic [NUM_LC-1:0][NUM_LC-1:0] connHit;
  logic [MAP_BITS-1:0]           covMap;
  logic [MAP_BITS-1:0]           effMap;
  logic [MAP_BITS-1:0]           newBits;

  // pairwise comparators over transmitters i<j
  genvar gi, gj;
  generate
    for (gi = 0; gi < NUM_LC; gi++) begin : g_row
      for (gj = 0; gj < NUM_LC; gj++) begin : g_col
        if (gj > gi) begin : g_cmp
          logic [DEST_W-1:0] destI, destJ;
          logic [CONN_W-1:0] connI, connJ;
          assign destI = slotDest[gi*DEST_W +: DEST_W];
          assign destJ = slotDest[gj*DEST_W +: DEST_W];
          assign connI = slotConn[gi*CONN_W +: CONN_W];
          assign connJ = slotConn[gj*CONN_W +: CONN_W];
          assign dupHit[gi][gj]  = (destI == destJ);
          if ((gi / GRP_SIZE) == (gj / GRP_SIZE)) begin : g_same_src
            assign connHit[gi][gj] = ((32'(destI) / GRP_SIZE) == (32'(destJ) / GRP_SIZE))
                                     && (connI == connJ);
          end else begin : g_diff_src
            assign connHit[gi][gj] = 1'b0;
          end
        end else begin : g_none
          assign dupHit[gi][gj]  = 1'b0;
          assign connHit[gi][gj] = 1'b0;
        end
      end
    end
  endgenerate

  assign dupDest  = |dupHit;
  assign connOver = |connHit;

  // pairs scheduled by this slot, row = transmitter
  always_comb begin
    newBits = '0;
    for (int i = 0; i < NUM_LC; i++) begin
      if (32'(slotDest[i*DEST_W +: DEST_W]) < NUM_LC)
        newBits[i*NUM_LC + 32'(slotDest[i*DEST_W +: DEST_W])] = 1'b1;
    end
  end

  assign effMap     = mapCtl.freshFrame ? '0 : covMap;
  assign pairRepeat = |(effMap & newBits);
  assign coverFull  = &(effMap | newBits);

  always_ff @(posedge clk) begin
    if (!rstN)                   covMap <= '0;
    else if (mapCtl.wrapFrame)   covMap <= '0;
    else if (mapCtl.commit)      covMap <= effMap | newBits;
    else if (mapCtl.freshFrame)  covMap <= '0;
  end

endmodule

// File: rtl/tdm_sched_ctl.sv
module tdm_sched_ctl
  import tdm_sched_pkg::*;
#(
  parameter int NUM_LC = 8
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       slotValid,
  input  logic       frameStart,
  input  logic       dupDest,
  input  logic       connOver,
  input  logic       pairRepeat,
  input  logic       coverFull,
  output map_ctl_t   mapCtl,
  output logic       slotErr,
  output logic [2:0] errCause,
  output logic       frameDone,
  output logic       frameOk
);

  localparam int CNT_W = (NUM_LC > 1) ? $clog2(NUM_LC) : 1;
  localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(NUM_LC - 1);

  logic [CNT_W-1:0] slotCnt, slotIdx;
  logic             errSeen, errSeenEff, lastSlot;
  cause_e           cause;

  always_comb begin
    slotIdx    = frameStart ? '0 : slotCnt;
    errSeenEff = frameStart ? 1'b0 : errSeen;
    lastSlot   = slotValid && (slotIdx == LAST_IDX);

    if      (dupDest)                  cause = CAUSE_DUP_DEST;
    else if (connOver)                 cause = CAUSE_CONN_OVER;
    else if (pairRepeat)               cause = CAUSE_PAIR_REPEAT;
    else if (lastSlot && !coverFull)   cause = CAUSE_PAIR_MISS;
    else                               cause = CAUSE_NONE;

    mapCtl.commit     = slotValid;
    mapCtl.freshFrame = frameStart;
    mapCtl.wrapFrame  = lastSlot;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      slotCnt   <= '0;
      errSeen   <= 1'b0;
      slotErr   <= 1'b0;
      errCause  <= 3'd0;
      frameDone <= 1'b0;
      frameOk   <= 1'b0;
    end else begin
      if (slotValid) begin
        slotCnt <= lastSlot ? '0 : slotIdx + CNT_W'(1);
        errSeen <= lastSlot ? 1'b0 : (errSeenEff || (cause != CAUSE_NONE));
      end else if (frameStart) begin
        slotCnt <= '0;
        errSeen <= 1'b0;
      end
      slotErr   <= slotValid && (cause != CAUSE_NONE);
      errCause  <= slotValid ? cause : CAUSE_NONE;
      frameDone <= lastSlot;
      frameOk   <= lastSlot && !errSeenEff && (cause == CAUSE_NONE);
    end
  end

endmodule

// File: rtl/tdm_sched_check.sv
module tdm_sched_check
  import tdm_sched_pkg::*;
#(
  parameter int NUM_LC   = 8,
  parameter int GRP_SIZE = 4,
  localparam int NUM_GRP  = NUM_LC / GRP_SIZE,
  localparam int NUM_CONN = GRP_SIZE + NUM_GRP - 1,
  localparam int DEST_W   = (NUM_LC > 1) ? $clog2(NUM_LC) : 1,
  localparam int CONN_W   = (NUM_CONN > 1) ? $clog2(NUM_CONN) : 1
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     slotValid,
  input  logic                     frameStart,
  input  logic [NUM_LC*DEST_W-1:0] slotDest,
  input  logic [NUM_LC*CONN_W-1:0] slotConn,
  output logic                     slotErr,
  output logic [2:0]               errCause,
  output logic                     frameDone,
  output logic                     frameOk
);

  map_ctl_t mapCtl;
  logic     dupDest, connOver, pairRepeat, coverFull;

  tdm_sched_dp #(
    .NUM_LC(NUM_LC), .GRP_SIZE(GRP_SIZE), .NUM_CONN(NUM_CONN),
    .DEST_W(DEST_W), .CONN_W(CONN_W)
  ) u_dp (
    .clk(clk), .rstN(rstN), .mapCtl(mapCtl),
    .slotDest(slotDest), .slotConn(slotConn),
    .dupDest(dupDest), .connOver(connOver),
    .pairRepeat(pairRepeat), .coverFull(coverFull)
  );

  tdm_sched_ctl #(.NUM_LC(NUM_LC)) u_ctl (
    .clk(clk), .rstN(rstN), .slotValid(slotValid), .frameStart(frameStart),
    .dupDest(dupDest), .connOver(connOver), .pairRepeat(pairRepeat),
    .coverFull(coverFull), .mapCtl(mapCtl),
    .slotErr(slotErr), .errCause(errCause),
    .frameDone(frameDone), .frameOk(frameOk)
  );

endmodule

// File: rtl/tdm_sched_sva.sv
module tdm_sched_sva (
  input logic       clk,
  input logic       rstN,
  input logic       slotValid,
  input logic       slotErr,
  input logic [2:0] errCause,
  input logic       frameDone,
  input logic       frameOk
);

  a_r10_flag_matches_cause: assert property (@(posedge clk) disable iff (!rstN)
    slotErr == (errCause != 3'd0));

  a_r1_err_needs_slot: assert property (@(posedge clk) disable iff (!rstN)
    slotErr |-> $past(slotValid));

  a_r6_done_needs_slot: assert property (@(posedge clk) disable iff (!rstN)
    frameDone |-> $past(slotValid));

  a_r6_done_single: assert property (@(posedge clk) disable iff (!rstN)
    frameDone |=> !frameDone || $past(slotValid));

  a_r7_ok_with_done: assert property (@(posedge clk) disable iff (!rstN)
    frameOk |-> (frameDone && !slotErr));

  a_r8_miss_at_end: assert property (@(posedge clk) disable iff (!rstN)
    (errCause == 3'd4) |-> frameDone);

  a_r2_cause_range: assert property (@(posedge clk) disable iff (!rstN)
    errCause <= 3'd4);

endmodule

bind tdm_sched_check tdm_sched_sva u_sva (
  .clk(clk), .rstN(rstN), .slotValid(slotValid), .slotErr(slotErr),
  .errCause(errCause), .frameDone(frameDone), .frameOk(frameOk)
);

// File: tb/tdm_sched_check_bench.sv
`timescale 1ns/1ps
module tdm_sched_check_bench;

  localparam int N  = 8;
  localparam int L  = 4;
  localparam int DW = 3;
  localparam int CW = 3;
  localparam int NC = 5;

  logic            clk = 1'b0;
  logic            rstN = 1'b0;
  logic            slotValid = 1'b0;
  logic            frameStart = 1'b0;
  logic [N*DW-1:0] slotDest = '0;
  logic [N*CW-1:0] slotConn = '0;
  logic            slotErr, frameDone, frameOk;
  logic [2:0]      errCause;

  always #2.5 clk = ~clk;

  tdm_sched_check u_tdm_sched_check (
    .clk(clk), .rstN(rstN), .slotValid(slotValid), .frameStart(frameStart),
    .slotDest(slotDest), .slotConn(slotConn), .slotErr(slotErr),
    .errCause(errCause), .frameDone(frameDone), .frameOk(frameOk)
  );

  int checks = 0;
  int errors = 0;
  int dest[N];
  int conn[N];
  bit mMap[N][N];
  int mCnt = 0;
  bit mErr = 0;

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic string causeTag(int c);
    case (c)
      1: return "R2";
      2: return "R3";
      3: return "R4";
      4: return "R8";
      default: return "R1";
    endcase
  endfunction

  // schedule for cyclic shift s with connections assigned per group pair
  task automatic buildShift(int s);
    for (int i = 0; i < N; i++) begin
      int used = 0;
      dest[i] = (i + s) % N;
      for (int k = 0; k < i; k++)
        if (k / L == i / L && dest[k] / L == dest[i] / L) used++;
      conn[i] = used;
    end
  endtask

  task automatic runSlot(bit start, bit lowOnly);
    int  cause = 0;
    bit  dup = 0, over = 0, rep = 0, full = 1, last;
    int  idx = start ? 0 : mCnt;
    bit  errPrev = start ? 0 : mErr;
    bit  eff[N][N];
    int  expDone, expOk;
    for (int a = 0; a < N; a++)
      for (int b = 0; b < N; b++) eff[a][b] = start ? 1'b0 : mMap[a][b];
    for (int i = 0; i < N; i++)
      for (int j = i + 1; j < N; j++) begin
        if (dest[i] == dest[j]) dup = 1;
        if (i / L == j / L && dest[i] / L == dest[j] / L && conn[i] == conn[j]) over = 1;
      end
    for (int i = 0; i < N; i++) if (eff[i][dest[i]]) rep = 1;
    for (int i = 0; i < N; i++) eff[i][dest[i]] = 1'b1;
    for (int a = 0; a < N; a++)
      for (int b = 0; b < N; b++) if (!eff[a][b]) full = 0;
    last = (idx == N - 1);
    if (dup) cause = 1;
    else if (over) cause = 2;
    else if (rep) cause = 3;
    else if (last && !full) cause = 4;
    expDone = last;
    expOk   = last && !errPrev && cause == 0;
    // drive
    @(negedge clk);
    frameStart = start;
    slotValid  = 1'b1;
    for (int i = 0; i < N; i++) begin
      slotDest[i*DW +: DW] = DW'(dest[i]);
      slotConn[i*CW +: CW] = CW'(conn[i]);
    end
    @(negedge clk);
    slotValid  = 1'b0;
    frameStart = 1'b0;
    if (!lowOnly) begin
      chk({causeTag(cause), " R5 cause"}, int'(errCause), cause);
      chk("R10 slotErr", int'(slotErr), int'(cause != 0));
      chk("R6 frameDone", int'(frameDone), expDone);
      chk("R7 frameOk", int'(frameOk), expOk);
    end
    // model update
    for (int a = 0; a < N; a++)
      for (int b = 0; b < N; b++) mMap[a][b] = last ? 1'b0 : eff[a][b];
    mErr = last ? 1'b0 : (errPrev || cause != 0);
    mCnt = last ? 0 : idx + 1;
    // idle cycle: nothing reported (R1)
    @(negedge clk);
    chk("R1 idle quiet", int'(slotErr) + int'(frameDone) + int'(frameOk) + int'(errCause), 0);
  endtask

  task automatic loneStart();
    @(negedge clk);
    frameStart = 1'b1;
    @(negedge clk);
    frameStart = 1'b0;
    for (int a = 0; a < N; a++)
      for (int b = 0; b < N; b++) mMap[a][b] = 1'b0;
    mCnt = 0;
    mErr = 0;
  endtask

  initial begin
    #1000000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int order[N];
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    chk("R10 reset slotErr", int'(slotErr), 0);
    chk("R10 reset frameOk", int'(frameOk) + int'(frameDone) + int'(errCause), 0);
    rstN = 1'b1;
    @(negedge clk);

    // clean frame, start with first slot (R9, R6, R7)
    for (int s = 0; s < N; s++) begin buildShift(s); runSlot(s == 0, 0); end

    // duplicate destination only (R2)
    buildShift(0); dest[1] = dest[6]; conn[1] = 3;
    runSlot(1, 0);
    // dup + over together: lowest code (R5)
    buildShift(0); dest[0] = 5; dest[1] = 5; conn[0] = 0; conn[1] = 0;
    runSlot(1, 0);
    // over only (R3)
    buildShift(0); conn[1] = conn[0];
    runSlot(1, 0);
    // same index on different group pairs is legal (R3)
    buildShift(0); for (int i = 0; i < N; i++) conn[i] = i % L;
    runSlot(1, 0);

    // repeated pair then missing pair at end (R4, R8)
    buildShift(0); runSlot(1, 0);
    buildShift(0); runSlot(0, 0);
    for (int s = 2; s < N; s++) begin buildShift(s); runSlot(0, 0); end

    // lone frame start mid-frame clears history (R9)
    for (int s = 0; s < 3; s++) begin buildShift(s); runSlot(s == 0, 0); end
    buildShift(3); dest[0] = dest[1]; runSlot(0, 0);
    loneStart();
    for (int s = 0; s < N; s++) begin buildShift(s); runSlot(0, 0); end

    // random frames: shuffled shifts with occasional corruption
    for (int f = 0; f < 25; f++) begin
      for (int i = 0; i < N; i++) order[i] = i;
      for (int i = N - 1; i > 0; i--) begin
        int k = int'($urandom % (i + 1));
        int t = order[i]; order[i] = order[k]; order[k] = t;
      end
      for (int s = 0; s < N; s++) begin
        int a = int'($urandom % N);
        int b = int'($urandom % N);
        buildShift(order[s]);
        case ($urandom % 6)
          1: dest[a] = dest[b];
          2: conn[a] = conn[b];
          3: conn[a] = int'($urandom % NC);
          default: ;
        endcase
        runSlot(s == 0, 0);
      end
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule